// File: doc/BRIEF.md
# Display descriptor fetcher

This block is the frame-fetch engine at the front of a display controller. Each of its channels follows a linked list of descriptors held in system memory. It reads the data that each descriptor points to and sends that data, one 32-bit word at a time, to the pixel pipeline downstream. Every word carries a tag that marks it either as colour-table data or as pixel data. Channel 0 feeds the only panel, or the upper panel when two panels are driven. Channel 1 feeds the lower panel and runs only in dual-panel mode.

Software writes the start address of each channel while the block is disabled, and then sets the enable bit. The descriptors themselves decide the pattern of fetches:
- A descriptor that links to itself re-reads the same frame buffer on every frame, which suits true-colour modes.
- A colour-table descriptor and a frame descriptor that link to each other make the channel alternate between a table load and a frame fetch. This suits indexed modes below 12 bits per pixel. The table length in bytes is twice the entry count: 256 entries at 8 bpp, 16 entries otherwise.
- In dual-panel mode, each channel moves half of the frame bytes. Channel 1 starts at the frame base plus that half.

Both channels share one memory read port and one output stream. A round-robin arbiter grants the port. A one-cycle end-of-frame pulse reports the ID of each descriptor that completes.

Top module: `disp_dma_fetch`

## Requirements
- R1: A descriptor is four words read at ascending byte addresses A, A+4, A+8, A+12, in this order: link address, source address, frame ID, command. All memory addresses issued are word aligned.
- R2: Command bits [20:0] give a length in bytes. The channel reads ceil(length/4) words from the source address upward and emits each word as one stream beat, in address order.
- R3: Command bit 26 set makes every beat of that descriptor carry out_pal_o=1. Otherwise out_pal_o=0.
- R4: After the last word of a transfer, the channel reads the descriptor at the link address. A self-link repeats the same buffer. Two descriptors linked to each other make colour-table and pixel transfers alternate.
- R5: Each completed descriptor raises its channel's bit of eof_o for exactly one cycle, with eof_id_o equal to its frame ID. The pulse comes in the cycle after the final read is acknowledged. At most one eof_o bit is high at a time.
- R6: A descriptor whose length is zero produces no beats but still produces its end-of-frame pulse, and its link is followed.
- R7: Config address 0 is control (bit 0 enable, bit 1 dual-panel). Addresses 1 and 2 hold the start addresses of channels 0 and 1. Writes to the start addresses, and to the dual-panel bit, are ignored while enable is set.
- R8: A 0-to-1 change of enable starts channel 0 at its start address, and starts channel 1 only when dual-panel is set. A channel that is not started emits no beats.
- R9: After enable is cleared, at most one further read is acknowledged, and its word is still delivered. Then the memory request stays low.
- R10: When both channels want the port, grants alternate between them, so neither channel starves.
- R11: mem_req_o is held with a stable address until mem_ack_i, which returns data in the same cycle and may come in the request cycle. out_valid_o with stable data and tags is held until out_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 2 | Config register select |
| cfg_wdata_i | input | 32 | Config write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| out_valid_o | output | 1 | Stream beat valid |
| out_ready_i | input | 1 | Stream beat accepted |
| out_data_o | output | 32 | Stream word |
| out_pal_o | output | 1 | Beat is colour-table data |
| out_ch_o | output | 1 | Channel that produced the beat |
| eof_o | output | 2 | End-of-frame pulse per channel |
| eof_id_o | output | 32 | Frame ID of the completed descriptor |

## Verification
A channel can finish a descriptor in the same cycle that its next descriptor fetch competes with the other channel's data read. A clear of enable can also land while a read is outstanding. The dual-panel run keeps both channels requesting under random stall of the output and random memory latency. Its checks require near-equal beat counts and per-channel streams that match a bench walk of the descriptor chains. Every run ends by clearing enable mid-flight, and the bench then counts the acknowledges that follow and watches for a silent port.

// File: rtl/disp_dma_pkg.sv
`timescale 1ns/1ps
package disp_dma_pkg;
  localparam int unsigned DEF_NCH     = 2;
  localparam int unsigned DEF_AW      = 32;
  localparam int unsigned DEF_DW      = 32;
  localparam int unsigned DEF_LEN_W   = 21;
  localparam int unsigned DEF_PAL_BIT = 26;

  typedef enum logic [1:0] {CH_IDLE, CH_DESC, CH_DATA} ch_state_e;
endpackage

// File: rtl/disp_dma_regs.sv
`timescale 1ns/1ps
module disp_dma_regs #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  localparam int unsigned CAW = $clog2(NCH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [CAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           en_o,
  output logic           start_o,
  output logic [NCH-1:0] act_o,
  output logic [AW-1:0]  fdadr_o [NCH]
);
  logic en_q, en_d, dual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      en_d   <= 1'b0;
      dual_q <= 1'b0;
    end else begin
      en_d <= en_q;
      if (we_i && addr_i == '0) begin
        en_q <= wdata_i[0];
        if (!en_q) dual_q <= wdata_i[1];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AW-1:0] fd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fd_q <= '0;
      else if (we_i && !en_q && addr_i == CAW'(c + 1)) fd_q <= AW'(wdata_i);
    end
    assign fdadr_o[c] = fd_q;
    if (c == 0) begin : g_main
      assign act_o[c] = 1'b1;
    end else begin : g_dual
      assign act_o[c] = dual_q;
    end
  end

  assign en_o    = en_q;
  assign start_o = en_q && !en_d;
endmodule

// File: rtl/disp_dma_chan.sv
`timescale 1ns/1ps
module disp_dma_chan
  import disp_dma_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned LEN_W   = 21,
  parameter int unsigned PAL_BIT = 26,
  localparam int unsigned CW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          act_i,
  input  logic [AW-1:0] fdadr_i,
  input  logic          buf_full_i,
  input  logic          own_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          beat_o,
  output logic          pal_o,
  output logic          done_o,
  output logic [DW-1:0] done_id_o
);
  ch_state_e     st_q;
  logic [1:0]    wsel_q;
  logic [AW-1:0] base_q, nxt_q, src_q;
  logic [DW-1:0] fid_q;
  logic          pal_q;
  logic [CW-1:0] words_q, idx_q;
  logic [CW:0]   len_words;
  logic          last_desc, last_data;

  // byte length rounded up to whole words
  assign len_words = ({1'b0, rdata_i[LEN_W-1:0]} + (CW+1)'(3)) >> 2;
  assign last_desc = (st_q == CH_DESC) && (wsel_q == 2'd3);
  assign last_data = (st_q == CH_DATA) && (({1'b0, idx_q} + (CW+1)'(1)) == {1'b0, words_q});

  assign req_o  = en_i && ((st_q == CH_DESC) || (st_q == CH_DATA && !buf_full_i));
  assign addr_o = (st_q == CH_DATA) ? src_q + AW'({idx_q, 2'b00})
                                    : base_q + AW'({wsel_q, 2'b00});
  assign beat_o    = ack_i && (st_q == CH_DATA);
  assign pal_o     = pal_q;
  assign done_o    = ack_i && ((last_desc && len_words == '0) || last_data);
  assign done_id_o = fid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CH_IDLE;
      wsel_q  <= '0;
      base_q  <= '0;
      nxt_q   <= '0;
      src_q   <= '0;
      fid_q   <= '0;
      pal_q   <= 1'b0;
      words_q <= '0;
      idx_q   <= '0;
    end else begin
      unique case (st_q)
        CH_IDLE: begin
          if (start_i && act_i && en_i) begin
            st_q   <= CH_DESC;
            base_q <= fdadr_i;
            wsel_q <= '0;
          end
        end
        CH_DESC: begin
          if (ack_i) begin
            wsel_q <= wsel_q + 2'd1;
            unique case (wsel_q)
              2'd0: nxt_q <= AW'(rdata_i);
              2'd1: src_q <= AW'(rdata_i);
              2'd2: fid_q <= rdata_i;
              default: begin
                pal_q   <= rdata_i[PAL_BIT];
                words_q <= len_words[CW-1:0];
                idx_q   <= '0;
                if (len_words == '0) base_q <= nxt_q;
                else                 st_q   <= CH_DATA;
              end
            endcase
          end
        end
        CH_DATA: begin
          if (ack_i) begin
            idx_q <= idx_q + CW'(1);
            if (last_data) begin
              base_q <= nxt_q;
              wsel_q <= '0;
              st_q   <= CH_DESC;
            end
          end
        end
        default: st_q <= CH_IDLE;
      endcase
      // disabled: finish only an outstanding word, then park
      if (!en_i && (ack_i || !own_i)) st_q <= CH_IDLE;
    end
  end
endmodule

// File: rtl/disp_dma_arb.sv
`timescale 1ns/1ps
module disp_dma_arb #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 32,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [AW-1:0]  addr_i [NCH],
  input  logic           mem_ack_i,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [NCH-1:0] ack_o,
  output logic [NCH-1:0] own_o,
  output logic [IW-1:0]  sel_o
);
  logic          lock_q, found;
  logic [IW-1:0] owner_q, last_q, win, sel;

  always_comb begin
    int unsigned cand;
    win   = '0;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      cand = (int'(last_q) + k) % NCH;
      if (!found && req_i[cand]) begin
        found = 1'b1;
        win   = IW'(cand);
      end
    end
  end

  assign sel        = lock_q ? owner_q : win;
  assign mem_req_o  = lock_q || found;
  assign mem_addr_o = addr_i[sel];
  assign sel_o      = sel;

  for (genvar c = 0; c < NCH; c++) begin : g_gnt
    assign ack_o[c] = mem_ack_i && mem_req_o && (sel == IW'(c));
    assign own_o[c] = lock_q && (owner_q == IW'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(NCH - 1);
    end else if (mem_req_o) begin
      if (mem_ack_i) begin
        lock_q <= 1'b0;
        last_q <= sel;
      end else begin
        lock_q  <= 1'b1;
        owner_q <= sel;
      end
    end
  end
endmodule

// File: rtl/disp_dma_fetch.sv
`timescale 1ns/1ps
module disp_dma_fetch
  import disp_dma_pkg::*;
#(
  parameter int unsigned NCH     = DEF_NCH,
  parameter int unsigned AW      = DEF_AW,
  parameter int unsigned DW      = DEF_DW,
  parameter int unsigned LEN_W   = DEF_LEN_W,
  parameter int unsigned PAL_BIT = DEF_PAL_BIT,
  localparam int unsigned CAW = $clog2(NCH + 1),
  localparam int unsigned IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CAW-1:0] cfg_addr_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_ack_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [DW-1:0]  out_data_o,
  output logic           out_pal_o,
  output logic [IW-1:0]  out_ch_o,
  output logic [NCH-1:0] eof_o,
  output logic [DW-1:0]  eof_id_o
);
  logic           en, start;
  logic [NCH-1:0] act, req, ack, own, beat, pal, done;
  logic [AW-1:0]  fdadr [NCH];
  logic [AW-1:0]  addr [NCH];
  logic [DW-1:0]  done_id [NCH];
  logic [IW-1:0]  sel;
  logic           buf_q, bpal_q;
  logic [DW-1:0]  bdata_q, eid_q, eid_d;
  logic [IW-1:0]  bch_q;
  logic [NCH-1:0] eof_q;

  disp_dma_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .en_o(en), .start_o(start), .act_o(act), .fdadr_o(fdadr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    disp_dma_chan #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .PAL_BIT(PAL_BIT)) u_chan (
      .clk_i, .rst_ni,
      .en_i(en), .start_i(start), .act_i(act[c]), .fdadr_i(fdadr[c]),
      .buf_full_i(buf_q), .own_i(own[c]), .ack_i(ack[c]), .rdata_i(mem_rdata_i),
      .req_o(req[c]), .addr_o(addr[c]), .beat_o(beat[c]), .pal_o(pal[c]),
      .done_o(done[c]), .done_id_o(done_id[c])
    );
  end

  disp_dma_arb #(.NCH(NCH), .AW(AW)) u_arb (
    .clk_i, .rst_ni,
    .req_i(req), .addr_i(addr), .mem_ack_i,
    .mem_req_o, .mem_addr_o, .ack_o(ack), .own_o(own), .sel_o(sel)
  );

  always_comb begin
    eid_d = '0;
    for (int c = 0; c < NCH; c++) if (done[c]) eid_d = done_id[c];
  end

  // single-entry output stage; data reads are issued only when it is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= 1'b0;
      bdata_q <= '0;
      bpal_q  <= 1'b0;
      bch_q   <= '0;
      eof_q   <= '0;
      eid_q   <= '0;
    end else begin
      if (|beat) begin
        buf_q   <= 1'b1;
        bdata_q <= mem_rdata_i;
        bpal_q  <= pal[sel];
        bch_q   <= sel;
      end else if (out_ready_i) begin
        buf_q <= 1'b0;
      end
      eof_q <= done;
      if (|done) eid_q <= eid_d;
    end
  end

  assign out_valid_o = buf_q;
  assign out_data_o  = bdata_q;
  assign out_pal_o   = bpal_q;
  assign out_ch_o    = bch_q;
  assign eof_o       = eof_q;
  assign eof_id_o    = eid_q;
endmodule

// File: rtl/disp_dma_fetch_chk.sv
`timescale 1ns/1ps
module disp_dma_fetch_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned IW  = 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           cfg_we_i,
  input logic           mem_req_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_ack_i,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [DW-1:0]  out_data_o,
  input logic           out_pal_o,
  input logic [IW-1:0]  out_ch_o,
  input logic [NCH-1:0] eof_o
);
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R11

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_pal_o) && $stable(out_ch_o))); // R11

  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R1

  AST_EOF_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eof_o)); // R5

  AST_EOF_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eof_o) |-> $past(mem_req_o && mem_ack_i)); // R5

  AST_BEAT_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(mem_req_o && mem_ack_i)); // R2

  AST_STOP_AFTER_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cfg_we_i && mem_req_o && mem_ack_i) |=> !mem_req_o); // R9
endmodule

bind disp_dma_fetch disp_dma_fetch_chk #(.NCH(NCH), .AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .cfg_we_i(cfg_we_i),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .out_pal_o(out_pal_o), .out_ch_o(out_ch_o), .eof_o(eof_o)
);

// File: tb/tb_disp_dma_fetch.sv
`timescale 1ns/1ps
module tb_disp_dma_fetch;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req_o, mem_ack = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata = '0;
  logic        out_valid_o, out_ready = 1'b0, out_pal_o;
  logic [31:0] out_data_o, eof_id_o;
  logic [0:0]  out_ch_o;
  logic [1:0]  eof_o;

  disp_dma_fetch dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .mem_req_o, .mem_addr_o, .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .out_valid_o, .out_ready_i(out_ready), .out_data_o, .out_pal_o, .out_ch_o,
    .eof_o, .eof_id_o
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [1024];
  logic [31:0] wdesc [2];
  int          widx [2];
  logic [31:0] eq0 [$];
  logic [31:0] eq1 [$];
  int          eofc [2], beatc [2];
  int          palc, pixc, zeroc, acks, logn, lat;
  logic [31:0] alog [4];
  bit          chx [2];
  bit          bp;
  int          checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dcmd_words(input logic [31:0] d);
    logic [31:0] cmd;
    cmd = mem[int'(d[11:2]) + 3];
    return (int'(cmd[20:0]) + 3) >> 2;
  endfunction

  task automatic on_beat(input int c, input logic [31:0] data, input logic pal);
    logic [31:0] d, src, cmd;
    if (!chx[c]) begin
      chk(1'b0, "R8 beat from channel not started", 32'(c), 32'hffff);
      return;
    end
    d = wdesc[c];
    if (widx[c] >= dcmd_words(d)) begin
      chk(1'b0, "R4 beat past descriptor end", 32'(widx[c]), 32'(dcmd_words(d)));
      return;
    end
    src = mem[int'(d[11:2]) + 1];
    cmd = mem[int'(d[11:2]) + 3];
    chk(data == mem[int'(src[11:2]) + widx[c]], "R2 beat data", data, mem[int'(src[11:2]) + widx[c]]);
    chk(pal == cmd[26], "R3 palette tag", 32'(pal), 32'(cmd[26]));
    if (pal) palc++; else pixc++;
    widx[c]++;
    beatc[c]++;
  endtask

  task automatic drain_walk();
    logic [31:0] id, d;
    for (int c = 0; c < 2; c++) begin
      forever begin
        d = wdesc[c];
        if (widx[c] != dcmd_words(d)) break;
        if (c == 0 && eq0.size() == 0) break;
        if (c == 1 && eq1.size() == 0) break;
        id = (c == 0) ? eq0.pop_front() : eq1.pop_front();
        chk(id == mem[int'(d[11:2]) + 2], "R5 frame id", id, mem[int'(d[11:2]) + 2]);
        if (dcmd_words(d) == 0) zeroc++;
        wdesc[c] = mem[int'(d[11:2])];
        widx[c] = 0;
      end
    end
  endtask

  // memory model, stream sink and monitor
  initial begin
    lat = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req_o) begin
        if (lat == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = mem[mem_addr_o[11:2]];
          acks++;
          if (logn < 4) begin alog[logn] = mem_addr_o; logn++; end
          lat = $urandom % 3;
        end else lat--;
      end
      for (int c = 0; c < 2; c++)
        if (rst_n && eof_o[c]) begin
          if (c == 0) eq0.push_back(eof_id_o); else eq1.push_back(eof_id_o);
          eofc[c]++;
        end
      out_ready = bp ? (($urandom % 4) != 0) : 1'b1;
      if (rst_n && out_valid_o && out_ready) on_beat(int'(out_ch_o), out_data_o, out_pal_o);
      drain_walk();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] src,
                          input logic [31:0] id, input logic [31:0] cmd);
    mem[a >> 2] = nxt; mem[(a >> 2) + 1] = src; mem[(a >> 2) + 2] = id; mem[(a >> 2) + 3] = cmd;
  endtask

  task automatic start_run(input logic [31:0] s0, input logic [31:0] s1, input bit dual,
                           input bit prog, input bit bpv);
    bp = bpv;
    wdesc[0] = s0; wdesc[1] = s1; widx[0] = 0; widx[1] = 0;
    eq0.delete(); eq1.delete();
    eofc[0] = 0; eofc[1] = 0; beatc[0] = 0; beatc[1] = 0;
    palc = 0; pixc = 0; zeroc = 0; logn = 0;
    chx[0] = 1'b1; chx[1] = dual;
    if (prog) begin cfg(2'd1, s0); cfg(2'd2, s1); end
    cfg(2'd0, {30'd0, dual, 1'b1});
  endtask

  task automatic stop_run();
    int snap, b0, b1;
    @(negedge clk); #1;
    snap = acks;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'd0;
    @(negedge clk); #1;
    cfg_we = 1'b0;
    repeat (30) @(negedge clk);
    #1;
    chk(acks - snap <= 1, "R9 reads after disable", 32'(acks - snap), 32'd1);
    chk(mem_req_o == 1'b0, "R9 request low after disable", 32'(mem_req_o), 32'd0);
    while (out_valid_o) @(negedge clk);
    #1;
    b0 = beatc[0]; b1 = beatc[1]; snap = acks;
    repeat (40) @(negedge clk);
    #1;
    chk(beatc[0] + beatc[1] == b0 + b1 && acks == snap, "R9 quiet after disable",
        32'(beatc[0] + beatc[1] + acks), 32'(b0 + b1 + snap));
    chk(eq0.size() == 0 && eq1.size() == 0, "R5 no unmatched end-of-frame",
        32'(eq0.size() + eq1.size()), 32'd0);
  endtask

  task automatic wait_eof(input int t0, input int t1);
    while (eofc[0] < t0 || eofc[1] < t1) @(negedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    bp = 1'b0; acks = 0; logn = 0;
    chx[0] = 1'b0; chx[1] = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(mem_req_o == 1'b0 && out_valid_o == 1'b0 && eof_o == 2'b00, "R8 idle in reset",
        {mem_req_o, out_valid_o, eof_o}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(mem_req_o == 1'b0 && out_valid_o == 1'b0, "R8 idle until enabled",
        {mem_req_o, out_valid_o}, 32'd0);

    // S1: palette/frame ping-pong, 8 bpp table of 256 entries
    put_desc(32'h000, 32'h010, 32'h800, 32'hA0, 32'h0400_0200);
    put_desc(32'h010, 32'h000, 32'hC00, 32'hA1, 32'd40);
    start_run(32'h000, 32'h0, 1'b0, 1'b1, 1'b1);
    wait_eof(5, 0);
    stop_run();
    chk(alog[0] == 32'h000 && alog[1] == 32'h004 && alog[2] == 32'h008 && alog[3] == 32'h00C,
        "R1 descriptor word order", alog[3], 32'h00C);
    chk(palc >= 256 && pixc >= 20, "R4 alternating palette and frame", 32'(palc), 32'd256);

    // S2: true-colour self loop, length 37 bytes -> 10 words
    put_desc(32'h040, 32'h040, 32'hA00, 32'hB0, 32'd37);
    start_run(32'h040, 32'h0, 1'b0, 1'b1, 1'b0);
    wait_eof(3, 0);
    stop_run();
    chk(palc == 0, "R3 no palette in true-colour loop", 32'(palc), 32'd0);
    chk(pixc >= 30, "R4 self loop repeats frame", 32'(pixc), 32'd30);

    // S3: dual panel, each half 64 bytes, lower half at base+64
    put_desc(32'h080, 32'h080, 32'hD00, 32'hC0, 32'd64);
    put_desc(32'h090, 32'h090, 32'hD40, 32'hC1, 32'd64);
    start_run(32'h080, 32'h090, 1'b1, 1'b1, 1'b1);
    wait_eof(4, 4);
    chk(beatc[0] - beatc[1] <= 24 && beatc[1] - beatc[0] <= 24, "R10 round robin balance",
        32'(beatc[1]), 32'(beatc[0]));
    stop_run();
    chk(beatc[1] > 0, "R8 lower panel runs in dual mode", 32'(beatc[1]), 32'd1);

    // S4: zero-length descriptor in a loop with a 6-byte transfer
    put_desc(32'h0C0, 32'h0D0, 32'hE00, 32'h55, 32'h0400_0000);
    put_desc(32'h0D0, 32'h0C0, 32'hE40, 32'h56, 32'd6);
    start_run(32'h0C0, 32'h0, 1'b0, 1'b1, 1'b1);
    wait_eof(6, 0);
    stop_run();
    chk(zeroc >= 3, "R6 zero-length end-of-frame", 32'(zeroc), 32'd3);
    chk(palc == 0, "R6 zero-length issues no beats", 32'(palc), 32'd0);

    // S5: start address and dual writes ignored while enabled
    start_run(32'h040, 32'h0, 1'b0, 1'b1, 1'b1);
    wait_eof(1, 0);
    cfg(2'd1, 32'h0C0);
    cfg(2'd2, 32'h090);
    cfg(2'd0, 32'd3);
    wait_eof(2, 0);
    stop_run();
    start_run(32'h040, 32'h0, 1'b0, 1'b0, 1'b1);
    wait_eof(2, 0);
    stop_run();
    chk(alog[0] == 32'h040, "R7 start address kept", alog[0], 32'h040);
    chk(beatc[1] == 0, "R7 dual write ignored", 32'(beatc[1]), 32'd0);

    // S6: disable in the middle of a long palette transfer
    start_run(32'h000, 32'h0, 1'b0, 1'b1, 1'b1);
    while (beatc[0] < 37) @(negedge clk);
    stop_run();
    chk(eofc[0] == 0, "R9 stopped before end of frame", 32'(eofc[0]), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule